// File: doc/BRIEF.md
# Direct-Mapped Cache with Requested-Word-First Refill

This block is a direct-mapped, write-back cache placed between a processor load/store port and a slower memory that moves one word per transfer. A block holds several words. The word address is split into three fields: a tag, a line index and a word offset. A read that hits returns its word combinationally in the cycle it is presented. Any access that cannot finish in its cycle raises a stall. The processor holds the request unchanged until the stall drops.

On a miss the block chooses one of two paths. If the victim line is valid and has been modified, the cache first writes the victim's words back to memory. It then asks memory for the new block, starting at the word the processor wants. Memory returns the words in wrap-around order. The first returned word completes the stalled access in the cycle it arrives, and the remaining words fill in behind it. While this background fill runs, the processor can keep reading. It can read words that have already arrived, and it can read other lines that hit.

A write miss allocates the line. The write is merged in at the moment the first word arrives, and the line is marked modified.

Top module: `cwf_cache`

## Requirements
- R1: The word offset is the low log2(WORDS) address bits, the line index is the next log2(LINES) bits, and the tag is the rest. Two addresses with the same index and different tags evict each other. Addresses with different indexes can be resident together.
- R2: A read that hits a valid line with a matching tag, outside an unfinished fill word, completes in the cycle it is presented: stall stays low and the read data is the stored word. Stall is never high while no request is presented.
- R3: On a miss the cache issues exactly one memory read request. Its address is the full word address of the missing access (tag, index and offset).
- R4: Refill beat k is stored at offset (requested offset + k) mod WORDS. After the fill, every word of the block reads back the value memory held.
- R5: The stalled access completes in the cycle the first refill beat arrives. If it is a read, it returns that beat's data.
- R6: During a background fill, three cases apply. Reads of words already arrived do not stall. Reads of other resident lines do not stall. Reads of words not yet arrived stall until those words arrive, and then return the correct data.
- R7: A write sets the line's modified flag. A miss that evicts a modified line first performs WORDS write transfers, before its read request. These transfers carry the old tag and index, use offsets 0 through WORDS-1 in ascending order, and carry the line's current data.
- R8: A miss that evicts an invalid or unmodified line performs no write transfer.
- R9: A write miss allocates the line and fetches the whole block. The written word replaces the fetched word, and the line is marked modified, so a later eviction writes it back.
- R10: Reset invalidates every line and leaves the memory request low.
- R11: Memory request, address and direction stay stable until ready is seen. No new memory request starts while refill beats are still outstanding.
- R12: A write presented during a background fill stalls until the fill has finished, then completes as a normal hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when the access completes |
| cpu_stall | output | 1 | Access cannot complete this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write one word, 0 = read a block |
| mem_addr | output | ADDR_W | Memory word address (start word for reads) |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | One refill word present on mem_rdata |
| mem_rdata | input | DATA_W | Refill word |

## Verification
Some properties are checked on every cycle: handshake stability and the rule that nothing is issued while refill beats are outstanding, the ascending offsets and complete count of each write-back burst, the match between the read-request address and the missing address, and the release of the stall with bypassed data on the first beat. Only the bench scenarios can show the rest. They show that hit and miss follow the address split, and that wrapped beats land in the right words. They show which background reads stall and which do not, and that written data survives an eviction and comes back later. They also show that reset really invalidates the lines.

// File: rtl/cwf_cache_pkg.sv
package cwf_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,   // serving hits, detecting misses
    ST_EVICT,  // writing modified victim words out
    ST_ASK,    // read request outstanding
    ST_FILL    // refill words streaming in
  } ctl_state_e;
endpackage

// File: rtl/cwf_cache_tags.sv
module cwf_cache_tags #(
  parameter int LINES = 64,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  output logic [TAG_W-1:0] look_tag,
  output logic             look_valid,
  output logic             look_dirty,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             dirty_en,
  input  logic [IDX_W-1:0] dirty_idx
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (alloc_en) tag_q[alloc_idx] <= alloc_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (alloc_en) begin
        valid_q[alloc_idx] <= 1'b1;
        dirty_q[alloc_idx] <= 1'b0;
      end
      if (dirty_en) dirty_q[dirty_idx] <= 1'b1;
    end
  end

  assign look_tag   = tag_q[look_idx];
  assign look_valid = valid_q[look_idx];
  assign look_dirty = dirty_q[look_idx];
endmodule

// File: rtl/cwf_cache_ram.sv
module cwf_cache_ram #(
  parameter int DATA_W = 32,
  parameter int A_W    = 9,
  localparam int DEPTH = 1 << A_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [A_W-1:0]    waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [A_W-1:0]    raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/cwf_cache_ctrl.sv
module cwf_cache_ctrl
  import cwf_cache_pkg::*;
#(
  parameter int TAG_W = 21,
  parameter int IDX_W = 6,
  parameter int OFF_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic [TAG_W-1:0]         c_tag,
  input  logic [IDX_W-1:0]         c_idx,
  input  logic [OFF_W-1:0]         c_off,
  input  logic                     line_valid,
  input  logic                     line_dirty,
  input  logic [TAG_W-1:0]         line_tag,
  input  logic                     mem_ready,
  input  logic                     mem_rvalid,
  output logic                     cpu_stall,
  output logic                     bypass,
  output logic                     ram_we,
  output logic                     ram_sel_cpu,
  output logic [IDX_W+OFF_W-1:0]   ram_waddr,
  output logic [IDX_W+OFF_W-1:0]   ram_raddr,
  output logic                     alloc_en,
  output logic [IDX_W-1:0]         alloc_idx,
  output logic [TAG_W-1:0]         alloc_tag,
  output logic                     dirty_en,
  output logic [IDX_W-1:0]         dirty_idx,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [TAG_W+IDX_W+OFF_W-1:0] mem_addr
);
  localparam int WORDS = 1 << OFF_W;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

  ctl_state_e       state_q;
  logic [OFF_W-1:0] cnt_q;
  logic [TAG_W-1:0] m_tag_q, v_tag_q;
  logic [IDX_W-1:0] m_idx_q;
  logic [OFF_W-1:0] m_off_q;
  logic [WORDS-1:0] arrived_q;

  logic in_idle, in_evict, in_ask, in_fill;
  logic tag_hit, same_line, word_ok, first_beat, rd_ok, wr_ok;
  logic [OFF_W-1:0] fill_off;

  assign in_idle  = (state_q == ST_IDLE);
  assign in_evict = (state_q == ST_EVICT);
  assign in_ask   = (state_q == ST_ASK);
  assign in_fill  = (state_q == ST_FILL);

  assign tag_hit   = line_valid && (line_tag == c_tag);
  assign same_line = (c_idx == m_idx_q);
  assign word_ok   = !(in_fill && same_line) || arrived_q[c_off];
  assign fill_off  = m_off_q + cnt_q;

  // first refill beat of the pending access: completes it in this cycle
  assign first_beat = in_fill && mem_rvalid && (cnt_q == '0) && cpu_req &&
                      same_line && (c_tag == m_tag_q) && (c_off == m_off_q);

  assign rd_ok = !cpu_we && tag_hit && word_ok && (in_idle || in_fill);
  assign wr_ok = cpu_we && tag_hit && in_idle;

  assign cpu_stall = cpu_req && !(rd_ok || wr_ok || first_beat);
  assign bypass    = first_beat;

  assign ram_we      = (in_fill && mem_rvalid) || (cpu_req && wr_ok);
  assign ram_sel_cpu = in_fill ? (first_beat && cpu_we) : 1'b1;
  assign ram_waddr   = in_fill ? {m_idx_q, fill_off} : {c_idx, c_off};
  assign ram_raddr   = in_evict ? {m_idx_q, cnt_q} : {c_idx, c_off};

  assign alloc_en  = in_ask && mem_ready;
  assign alloc_idx = m_idx_q;
  assign alloc_tag = m_tag_q;
  assign dirty_en  = cpu_req && cpu_we && (wr_ok || first_beat);
  assign dirty_idx = c_idx;

  assign mem_req  = in_evict || in_ask;
  assign mem_we   = in_evict;
  assign mem_addr = in_evict ? {v_tag_q, m_idx_q, cnt_q} : {m_tag_q, m_idx_q, m_off_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      m_tag_q   <= '0;
      m_idx_q   <= '0;
      m_off_q   <= '0;
      v_tag_q   <= '0;
      arrived_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_req && !tag_hit) begin
            m_tag_q <= c_tag;
            m_idx_q <= c_idx;
            m_off_q <= c_off;
            v_tag_q <= line_tag;
            cnt_q   <= '0;
            state_q <= (line_valid && line_dirty) ? ST_EVICT : ST_ASK;
          end
        end
        ST_EVICT: begin
          if (mem_ready) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) state_q <= ST_ASK;
          end
        end
        ST_ASK: begin
          if (mem_ready) begin
            arrived_q <= '0;
            cnt_q     <= '0;
            state_q   <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rvalid) begin
            arrived_q[fill_off] <= 1'b1;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cwf_cache.sv
module cwf_cache #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int LINES  = 64,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int RA_W  = IDX_W + OFF_W;

  logic [TAG_W-1:0] c_tag, line_tag, alloc_tag;
  logic [IDX_W-1:0] c_idx, alloc_idx, dirty_idx;
  logic [OFF_W-1:0] c_off;
  logic             line_valid, line_dirty, alloc_en, dirty_en;
  logic             bypass, ram_we, ram_sel_cpu;
  logic [RA_W-1:0]  ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  assign c_off = cpu_addr[OFF_W-1:0];
  assign c_idx = cpu_addr[OFF_W +: IDX_W];
  assign c_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  cwf_cache_tags #(.LINES(LINES), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst(rst),
    .look_idx(c_idx), .look_tag(line_tag), .look_valid(line_valid), .look_dirty(line_dirty),
    .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_tag(alloc_tag),
    .dirty_en(dirty_en), .dirty_idx(dirty_idx)
  );

  cwf_cache_ram #(.DATA_W(DATA_W), .A_W(RA_W)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  cwf_cache_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .c_tag(c_tag), .c_idx(c_idx), .c_off(c_off),
    .line_valid(line_valid), .line_dirty(line_dirty), .line_tag(line_tag),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .cpu_stall(cpu_stall), .bypass(bypass),
    .ram_we(ram_we), .ram_sel_cpu(ram_sel_cpu), .ram_waddr(ram_waddr), .ram_raddr(ram_raddr),
    .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_tag(alloc_tag),
    .dirty_en(dirty_en), .dirty_idx(dirty_idx),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr)
  );

  assign ram_wdata = ram_sel_cpu ? cpu_wdata : mem_rdata;
  assign cpu_rdata = bypass ? mem_rdata : ram_rdata;
  assign mem_wdata = ram_rdata;
endmodule

// File: rtl/cwf_cache_chk.sv
module cwf_cache_chk #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic              mem_rvalid,
  input logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int CW    = OFF_W + 1;

  logic [CW-1:0]     wb_n_q, left_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic rd_hs, wr_hs, first;

  assign rd_hs = mem_req && mem_ready && !mem_we;
  assign wr_hs = mem_req && mem_ready && mem_we;
  assign first = mem_rvalid && (left_q == CW'(WORDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_n_q    <= '0;
      left_q    <= '0;
      rq_addr_q <= '0;
    end else if (rd_hs) begin
      wb_n_q    <= '0;
      left_q    <= CW'(WORDS);
      rq_addr_q <= mem_addr;
    end else begin
      if (wr_hs) wb_n_q <= wb_n_q + 1'b1;
      if (mem_rvalid && left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
  AST_QUIET_DURING_FILL: assert property (@(posedge clk) disable iff (rst)
    left_q != '0 |-> !mem_req); // R11
  AST_RESET_NO_REQ: assert property (@(posedge clk)
    rst |=> !mem_req); // R10
  AST_NO_IDLE_STALL: assert property (@(posedge clk) disable iff (rst)
    !cpu_req |-> !cpu_stall); // R2
  AST_READ_ADDR: assert property (@(posedge clk) disable iff (rst)
    rd_hs && cpu_req |-> mem_addr == cpu_addr); // R3
  AST_EVICT_ORDER: assert property (@(posedge clk) disable iff (rst)
    wr_hs |-> mem_addr[OFF_W-1:0] == wb_n_q[OFF_W-1:0]); // R7
  AST_EVICT_WHOLE: assert property (@(posedge clk) disable iff (rst)
    rd_hs |-> (wb_n_q == '0) || (wb_n_q == CW'(WORDS))); // R7
  AST_FIRST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    first && cpu_req && cpu_addr == rq_addr_q |-> !cpu_stall); // R5
  AST_FIRST_DATA: assert property (@(posedge clk) disable iff (rst)
    first && cpu_req && !cpu_we && cpu_addr == rq_addr_q |-> cpu_rdata == mem_rdata); // R5
endmodule

bind cwf_cache cwf_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) chk_i (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
);

// File: tb/cwf_cache_tb.sv
`timescale 1ns/1ps
module cwf_cache_tb_top;
  localparam int AW = 30, DW = 32, LINES = 64, WORDS = 8;
  localparam int MW = 12, MD = 1 << MW;

  logic clk, rst, cpu_req, cpu_we, cpu_stall, mem_req, mem_we, mem_ready, mem_rvalid;
  logic [AW-1:0] cpu_addr, mem_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;

  cwf_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(LINES), .WORDS(WORDS)) dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [DW-1:0] model [MD];
  logic [DW-1:0] ref_m [MD];

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hD000_0000 | DW'(a);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder
  int r_left = 0, r_wait = 0, r_k = 0, r_base = 0, r_off = 0;
  int rd_hs_n = 0, wb_n = 0, wb_before_rd = 0, beats_given = 0, last_rd_addr = 0;
  int wb_log [WORDS];

  initial begin
    mem_ready = 0; mem_rvalid = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ready = 0; mem_rvalid = 0;
      if (rst) begin
        r_left = 0; r_wait = 0;
      end else if (r_left > 0) begin
        if (r_wait > 0) r_wait--;
        else begin
          mem_rvalid = 1;
          mem_rdata = model[r_base + ((r_off + r_k) % WORDS)];
          r_k++; r_left--; beats_given++; r_wait = 1;
        end
      end else if (mem_req) begin
        if (r_wait > 0) r_wait--;
        else begin
          mem_ready = 1;
          if (mem_we) begin
            model[mem_addr[MW-1:0]] = mem_wdata;
            if (wb_n < WORDS) wb_log[wb_n] = int'(mem_addr[MW-1:0]);
            wb_n++; r_wait = 1;
          end else begin
            rd_hs_n++; last_rd_addr = int'(mem_addr[MW-1:0]); wb_before_rd = wb_n;
            r_base = int'(mem_addr[MW-1:0]) & ~(WORDS - 1);
            r_off = int'(mem_addr[2:0]); r_k = 0; r_left = WORDS; r_wait = 2; beats_given = 0;
          end
        end
      end
    end
  end

  task automatic access(input logic we, input int a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int st, output int bg);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = wd; st = 0;
    #1;
    while (cpu_stall) begin
      @(negedge clk); #1; st++;
    end
    rd = cpu_rdata; bg = beats_given;
    if (we) ref_m[a] = wd;
    @(posedge clk);
  endtask

  task automatic quiet();
    @(negedge clk); cpu_req = 0;
    while (mem_req || r_left != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // {we, addr[11:0], wdata[31:0], expect_miss}
  localparam logic [45:0] VEC [14] = '{
    {1'b0, 12'h015, 32'h0,          1'b1},
    {1'b0, 12'h015, 32'h0,          1'b0},
    {1'b0, 12'h010, 32'h0,          1'b0},
    {1'b1, 12'h013, 32'h1111_2222,  1'b0},
    {1'b0, 12'h013, 32'h0,          1'b0},
    {1'b0, 12'h213, 32'h0,          1'b1},
    {1'b0, 12'h013, 32'h0,          1'b1},
    {1'b0, 12'h0F8, 32'h0,          1'b1},
    {1'b1, 12'h4A7, 32'h0BAD_CAFE,  1'b1},
    {1'b0, 12'h4A0, 32'h0,          1'b0},
    {1'b0, 12'h4A7, 32'h0,          1'b0},
    {1'b0, 12'h0F8, 32'h0,          1'b0},
    {1'b0, 12'h6A1, 32'h0,          1'b1},
    {1'b0, 12'h4A7, 32'h0,          1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int st, bg, a, h0;
    for (int i = 0; i < MD; i++) begin model[i] = pat(i); ref_m[i] = pat(i); end
    rst = 1; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    chk(!mem_req, "R10", "mem_req in reset", DW'(mem_req), 0);
    chk(!cpu_stall, "R10", "stall in reset", DW'(cpu_stall), 0);
    rst = 0;

    // vector walk
    for (int i = 0; i < 14; i++) begin
      logic [45:0] v;
      v = VEC[i];
      a = int'(v[44:33]);
      access(v[45], a, v[32:1], rd, st, bg);
      chk((st > 0) == v[0], "R1", $sformatf("miss flag vec %0d", i), DW'(st > 0), DW'(v[0]));
      if (!v[45]) chk(rd == ref_m[a], "R2", $sformatf("read data vec %0d", i), rd, ref_m[a]);
      quiet();
    end

    // R3 R5 R6: requested word first, background fill
    h0 = rd_hs_n;
    access(0, 'h836, 0, rd, st, bg);
    chk(st > 0, "R3", "cold miss stalls", DW'(st), 1);
    chk(bg == 1, "R5", "released on first beat", DW'(bg), 1);
    chk(rd == pat('h836), "R5", "first beat data", rd, pat('h836));
    chk(last_rd_addr == 'h836, "R3", "read request address", DW'(last_rd_addr), DW'('h836));
    chk(rd_hs_n - h0 == 1, "R11", "one read request", DW'(rd_hs_n - h0), 1);
    access(0, 'h836, 0, rd, st, bg);
    chk(st == 0, "R6", "arrived word no stall", DW'(st), 0);
    access(0, 'h0F8, 0, rd, st, bg);
    chk(st == 0 && rd == ref_m['h0F8], "R6", "other line during fill", rd, ref_m['h0F8]);
    access(0, 'h835, 0, rd, st, bg);
    chk(st > 0, "R6", "late word stalls", DW'(st), 1);
    chk(rd == pat('h835), "R6", "late word data", rd, pat('h835));
    quiet();
    for (int k = 0; k < WORDS; k++) begin
      access(0, 'h830 + k, 0, rd, st, bg);
      chk(st == 0 && rd == pat('h830 + k), "R4", $sformatf("wrapped word %0d", k), rd, pat('h830 + k));
    end
    quiet();

    // R12: write during background fill
    access(0, 'h0C0, 0, rd, st, bg);
    access(1, 'h0F8, 32'hCAFE_0001, rd, st, bg);
    chk(st > 0, "R12", "write during fill stalls", DW'(st), 1);
    quiet();
    access(0, 'h0F8, 0, rd, st, bg);
    chk(st == 0 && rd == 32'hCAFE_0001, "R12", "write landed", rd, 32'hCAFE_0001);
    quiet();

    // R7: dirty victim written back in order before read
    wb_n = 0;
    access(0, 'h2F9, 0, rd, st, bg);
    quiet();
    chk(wb_n == WORDS, "R7", "writeback count", DW'(wb_n), WORDS);
    chk(wb_before_rd == WORDS, "R7", "writeback before read", DW'(wb_before_rd), WORDS);
    begin
      bit ok; ok = 1;
      for (int k = 0; k < WORDS; k++) if (wb_log[k] != 'h0F8 + k) ok = 0;
      chk(ok, "R7", "writeback address order", DW'(wb_log[1]), DW'('h0F9));
    end
    chk(model['h0F8] == 32'hCAFE_0001, "R7", "writeback data", model['h0F8], 32'hCAFE_0001);

    // R8: clean victim
    wb_n = 0;
    access(0, 'h0F8, 0, rd, st, bg);
    quiet();
    chk(wb_n == 0, "R8", "no writeback of clean line", DW'(wb_n), 0);
    chk(rd == 32'hCAFE_0001, "R8", "refetched data", rd, 32'hCAFE_0001);

    // R9: write miss allocate
    access(1, 'h555, 32'h600D_F00D, rd, st, bg);
    chk(st > 0, "R9", "write miss stalls", DW'(st), 1);
    quiet();
    access(0, 'h555, 0, rd, st, bg);
    chk(st == 0 && rd == 32'h600D_F00D, "R9", "written word kept", rd, 32'h600D_F00D);
    access(0, 'h550, 0, rd, st, bg);
    chk(st == 0 && rd == pat('h550), "R9", "fetched neighbour", rd, pat('h550));
    wb_n = 0;
    access(0, 'h755, 0, rd, st, bg);
    quiet();
    chk(wb_n == WORDS && model['h555] == 32'h600D_F00D, "R9", "allocated line dirty",
        model['h555], 32'h600D_F00D);

    // R1: different indexes coexist
    access(0, 'h000, 0, rd, st, bg); quiet();
    access(0, 'h008, 0, rd, st, bg); quiet();
    access(0, 'h000, 0, rd, st, bg);
    chk(st == 0, "R1", "index 0 still resident", DW'(st), 0);
    quiet();

    // R10: reset mid-run invalidates
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(!mem_req && !cpu_stall, "R10", "outputs in reset", DW'({mem_req, cpu_stall}), 0);
    rst = 0;
    access(0, 'h755, 0, rd, st, bg);
    chk(st > 0, "R10", "line invalid after reset", DW'(st), 1);
    quiet();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule